// File: doc/BRIEF.md
# Cascadable Synchronous Decimal/Binary Counter Stage

This block is a four-bit counting stage that runs entirely from one clock edge and can be chained into wider counters. An elaboration parameter selects the modulus. In decimal mode a stage steps through 0 to 9 and then returns to 0. In binary mode it steps through 0 to 15 and then returns to 0. Each stage has a synchronous active-low clear and a synchronous active-low parallel load from a four-bit data input. It also has two count-enable inputs, and it advances only when both are high.

Each stage drives a terminal-count carry. The carry is high for one cycle while the stage sits at its last value with both of its own enables high. In a chain, that carry drives both enables of the next stage up. A higher digit therefore advances on the same edge on which every lower digit wraps, and no stage takes its clock from another stage. The top module chains a parameter-set number of stages and exposes the concatenated count, with the least significant digit in bits [3:0].

Top module: `dcnt_chain`

## Requirements
- R1: All stages update on the same rising edge of `clk`. When the lower digit wraps from 9 to 0, the upper digit advances on that same edge (for example, 09 becomes 10 in one cycle).
- R2: In decimal mode, with both enables high, each digit steps 0,1,…,9 and then 0 on successive edges.
- R3: `carry_out` is high exactly when both top-level enables are high and every digit is at its terminal value (9 in decimal mode, 15 in binary mode). Otherwise it is low, including when both enables are low while the count is at its terminal value.
- R4: A clock edge with `clr_n` low sets the whole count to 0. This happens regardless of `load_n`, the enables and the data input.
- R5: A clock edge with `clr_n` high and `load_n` low copies `load_val` into the count, regardless of the enables. `load_val[3:0]` goes to the lowest digit.
- R6: With `clr_n` and `load_n` high, the count holds its value whenever `en_p` or `en_t` is low.
- R7: `carry_out` stays high for a single cycle while enables remain high. An upper digit advances only on an edge where all lower digits are at their terminal value with both enables high.
- R8: In decimal mode, a digit loaded with 10 to 15 counts upward to 15 and then wraps to 0. Along the way it raises no carry, and the digit above it does not advance.
- R9: In binary mode, a digit steps 0 to 15 and then wraps to 0. Its carry is high at 15 when its enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single shared clock, rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| load_val | input | 4*STAGES | Value to load; digit k in bits [4k+3:4k] |
| en_p | input | 1 | Count enable, first of two, active high |
| en_t | input | 1 | Count enable, second of two, active high |
| count | output | 4*STAGES | Concatenated count; lowest digit in bits [3:0] |
| carry_out | output | 1 | Terminal-count carry of the top digit, for further cascading |

## Verification
The embedded properties assume that the inputs are settled and free of unknowns at every rising edge. They also assume that a clear edge has occurred before any other behaviour is judged, since there is no reset other than the synchronous clear. The stimulus meets both assumptions. It drives every input only on the falling edge, holds each value for a full cycle, and opens with two cycles of clear before it changes anything else. It also steers the count through both wraps (09 to 10 and 99 to 00) and through over-range loaded values, so the terminal-count and out-of-range orderings are reached on purpose rather than by chance.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
   localparam int DIGIT_W = 4;
   typedef logic [DIGIT_W-1:0] digit_t;

   // Terminal value of a digit for the selected modulus
   function automatic digit_t term_value(input bit decimal);
      return decimal ? digit_t'(9) : digit_t'(15);
   endfunction
endpackage

// File: rtl/dcnt_term.sv
module dcnt_term
   import dcnt_pkg::*;
#(
   parameter bit DECIMAL = 1'b1
) (
   input  digit_t q,
   output logic   at_term
);
   generate
      if (DECIMAL) begin : g_dec
         // 1001 only; 1011/1101/1111 are over-range and not terminal
         assign at_term = (q == term_value(1'b1));
      end else begin : g_bin
         assign at_term = &q;
      end
   endgenerate
endmodule

// File: rtl/dcnt_stage.sv
module dcnt_stage
   import dcnt_pkg::*;
#(
   parameter bit DECIMAL = 1'b1
) (
   input  logic   clk,
   input  logic   clr_n,
   input  logic   load_n,
   input  digit_t din,
   input  logic   en_p,
   input  logic   en_t,
   output digit_t q,
   output logic   co
);
   logic   run;
   logic   at_term;
   digit_t nxt;

   assign run = en_p & en_t;

   dcnt_term #(.DECIMAL(DECIMAL)) u_term (
      .q       (q),
      .at_term (at_term)
   );

   always_comb begin
      nxt = q;
      if (!clr_n)       nxt = '0;
      else if (!load_n) nxt = din;
      else if (run)     nxt = at_term ? '0 : q + digit_t'(1);
   end

   always_ff @(posedge clk) q <= nxt;

   assign co = run & at_term;

   // ---- embedded checks ----
   logic primed = 1'b0;
   always_ff @(posedge clk) if (!clr_n) primed <= 1'b1;

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!primed)
      !clr_n |=> (q == '0)); // R4
   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && !load_n) |=> (q == $past(din))); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && load_n && !(en_p && en_t)) |=> $stable(q)); // R6
   AST_CARRY_SINGLE: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && load_n && co) |=> !co); // R7
   AST_TERM_WRAP: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && load_n && en_p && en_t && q == term_value(DECIMAL)) |=> (q == '0)); // R2
   AST_OVER_NO_CARRY: assert property (@(posedge clk) disable iff (!primed)
      (q > term_value(DECIMAL)) |-> !co); // R8
endmodule

// File: rtl/dcnt_chain.sv
module dcnt_chain
   import dcnt_pkg::*;
#(
   parameter int STAGES  = 2,
   parameter bit DECIMAL = 1'b1
) (
   input  logic                      clk,
   input  logic                      clr_n,
   input  logic                      load_n,
   input  logic [STAGES*DIGIT_W-1:0] load_val,
   input  logic                      en_p,
   input  logic                      en_t,
   output logic [STAGES*DIGIT_W-1:0] count,
   output logic                      carry_out
);
   localparam int CNT_W = STAGES * DIGIT_W;

   logic [STAGES-1:0] co;

   generate
      if (STAGES < 1 || STAGES > 8) begin : g_bad_stages
         $error("dcnt_chain: STAGES must lie in 1..8");
      end

      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         logic ep;
         logic et;
         if (g == 0) begin : g_first
            assign ep = en_p;
            assign et = en_t;
         end else begin : g_next
            assign ep = co[g-1];
            assign et = co[g-1];
         end

         dcnt_stage #(.DECIMAL(DECIMAL)) u_stage (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .din    (load_val[g*DIGIT_W +: DIGIT_W]),
            .en_p   (ep),
            .en_t   (et),
            .q      (count[g*DIGIT_W +: DIGIT_W]),
            .co     (co[g])
         );
      end
   endgenerate

   assign carry_out = co[STAGES-1];

   // ---- embedded checks ----
   logic primed = 1'b0;
   always_ff @(posedge clk) if (!clr_n) primed <= 1'b1;

   AST_FULL_ROLLOVER: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && load_n && carry_out) |=> (count == CNT_W'(0))); // R7
   AST_CARRY_NEEDS_EN: assert property (@(posedge clk) disable iff (!primed)
      carry_out |-> (en_p && en_t)); // R3
endmodule

// File: tb/dcnt_chain_test.sv
`timescale 1ns/1ps
module dcnt_chain_test;
   logic       clk = 1'b0;
   logic       clr_n = 1'b1;
   logic       load_n = 1'b1;
   logic [7:0] ld_val = '0;
   logic       en_p = 1'b0;
   logic       en_t = 1'b0;
   logic [7:0] count;
   logic       carry_out;
   logic [3:0] bcount;
   logic       bcarry;

   always #2 clk = ~clk;

   dcnt_chain #(.STAGES(2), .DECIMAL(1'b1)) uut (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .load_val(ld_val),
      .en_p(en_p), .en_t(en_t), .count(count), .carry_out(carry_out)
   );

   dcnt_chain #(.STAGES(1), .DECIMAL(1'b0)) uut_bin (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .load_val(ld_val[3:0]),
      .en_p(en_p), .en_t(en_t), .count(bcount), .carry_out(bcarry)
   );

   typedef struct {
      logic [7:0] cnt;
      logic [3:0] bcnt;
      string      tag;
   } exp_t;
   exp_t sbq[$];

   int  total = 0;
   int  bad = 0;
   bit  carry_on = 1'b0;
   logic [7:0] m_cnt = '0;
   logic [3:0] m_b = '0;

   task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [3:0] adv(input logic [3:0] q, input bit dec);
      if (dec && q == 4'd9) return 4'd0;
      return q + 4'd1;
   endfunction

   // driver: applies one cycle of inputs, checks carry, pushes expected count
   task automatic step(input bit c, input bit l, input logic [7:0] d,
                       input bit ep, input bit et, input string tag);
      bit en, c0, c1, cb;
      exp_t e;
      @(negedge clk);
      clr_n = c; load_n = l; ld_val = d; en_p = ep; en_t = et;
      #1;
      en = ep & et;
      c0 = en && (m_cnt[3:0] == 4'd9);
      c1 = c0 && (m_cnt[7:4] == 4'd9);
      cb = en && (m_b == 4'd15);
      if (carry_on) begin
         chk(tag, "carry_out", {7'd0, carry_out}, {7'd0, c1});
         chk(tag, "bin carry", {7'd0, bcarry}, {7'd0, cb});
      end
      if (!c) begin
         m_cnt = '0; m_b = '0;
      end else if (!l) begin
         m_cnt = d; m_b = d[3:0];
      end else begin
         if (c0) m_cnt[7:4] = adv(m_cnt[7:4], 1'b1);
         if (en) m_cnt[3:0] = adv(m_cnt[3:0], 1'b1);
         if (en) m_b = adv(m_b, 1'b0);
      end
      e.cnt = m_cnt; e.bcnt = m_b; e.tag = tag;
      sbq.push_back(e);
   endtask

   // monitor: compares each produced count with the queued expectation
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk(e.tag, "count", count, e.cnt);
            chk(e.tag, "bin count", {4'd0, bcount}, {4'd0, e.bcnt});
         end
      end
   end

   initial begin
      #(4 * 5000);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      step(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R4 reset clear");
      step(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R4 reset clear");
      carry_on = 1'b1;
      // R1 R2: 0..24 passes 09->10 and 19->20 in single edges
      for (int i = 0; i < 25; i++) step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R1/R2 count");
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, "R6 en_p low");
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 8'h00, 1'b1, 1'b0, "R6 en_t low");
      step(1'b1, 1'b0, 8'h37, 1'b0, 1'b0, "R5 load no enable");
      for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R5 count after load");
      step(1'b0, 1'b0, 8'h55, 1'b1, 1'b1, "R4 clear over load");
      step(1'b1, 1'b0, 8'h97, 1'b1, 1'b1, "R5 load over count");
      for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R3/R7 rollover");
      step(1'b1, 1'b0, 8'h99, 1'b1, 1'b1, "R5 load 99");
      step(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, "R3 carry gated");
      step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R3 carry at 99");
      step(1'b1, 1'b0, 8'h2B, 1'b1, 1'b1, "R8 load over-range");
      for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R8 over-range count");
      step(1'b0, 1'b1, 8'h00, 1'b1, 1'b1, "R4 clear");
      for (int i = 0; i < 18; i++) step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R9 binary wrap");
      step(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, "R6 idle");
      @(negedge clk);
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule